// File: doc/BRIEF.md
# B-Channel HDLC FIFO Command and Status Front End

This block sits between a host register interface and a byte-serial HDLC framer for one B channel. The host programs a 32-bit control word, pushes transmit data and pulls receive data as 32-bit little-endian words, and polls a 32-bit status word. The framer pulls transmit bytes one at a time and pushes received bytes together with an end-of-frame marker and a 3-bit frame check pattern. Flag generation, bit stuffing and CRC work stay in the framer. This block only receives the mode byte and the idle fill byte from the control word.

Data moves in blocks. A transmit block becomes available to the framer once the host has written enough words to cover the programmed length. A receive block is handed to the host when the FIFO fills or a frame ends. Three latched interrupt flags tell the host when to act: transmit pool ready, transmit underrun and receive pool ready. Reading the status word clears these flags. Transmit and receive reset commands flush the matching direction. The FIFO depth is 32 or 128 bytes, chosen by a mode bit.

Top module: `hdlc_chan_if`

## Requirements
- R1: After reset the status word holds only the version field, `irq` is low and `fr_tx_valid` is low. The FIFO size is 32 bytes and the mode is HDLC.
- R2: A control write stores the command byte (bits 7:0), transmit length (15:8), mode (23:16) and fill (31:24). The mode byte appears on `fr_mode` and the fill byte on `fr_fill`. Command bit 7 is transmit reset, bit 5 is receive reset and bit 0 is message end.
- R3: The transmit block length is the length field, or the full FIFO size (128 if mode bit 5 is set, else 32) when the field is zero. Bytes go out least significant byte of each word first. Padding bytes beyond the length are never sent. Words written while a block waits for the framer are dropped.
- R4: A byte request in one cycle gives `fr_tx_valid` with the byte in the next cycle, and only then.
- R5: In HDLC mode (mode bit 1 clear) with command bit 0 set, `fr_tx_end` marks the last byte of the block. In transparent mode it is never raised.
- R6: Status bit 7 (transmit pool ready) sets when the last byte of a block is sent and on every transmit reset.
- R7: Status bit 6 (underrun) sets when the framer requests a byte, no block is loaded, and the current frame has not been closed by a message-end byte.
- R8: Transmit reset drops a loaded block and closes the open frame. Later requests return no byte and raise no underrun.
- R9: A receive block closes when the FIFO size is reached, or at an end byte in HDLC mode. Closing sets status bit 5. Bits 14:8 give the block length, with a full block reading as zero. An end byte in transparent mode is ignored.
- R10: When a block is closed by an end byte, status bit 0 is set and bits 3:1 copy the framer's check pattern (0b011 means a good frame). Otherwise both fields read zero.
- R11: Receive reads return the block as little-endian words, with the unused bytes of the last word zero. After the last word the block is released and the length and end fields read zero. A read with no block pending returns zero.
- R12: A byte that arrives while a block is pending is dropped and sets status bit 4 (overflow). Only a receive reset clears bit 4, and the reset also drops the pending block.
- R13: A status read clears bits 7:5, but an event in the same cycle keeps its bit set. `irq` is high while any of those bits is set.
- R14: Status bits 27:24 report the VERSION parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ctrl_wr | input | 1 | Control word write strobe |
| host_ctrl_wdata | input | 32 | Control word: fill, mode, length, command |
| host_stat_rd | input | 1 | Status read strobe, clears interrupt flags |
| stat_word | output | 32 | Status word |
| irq | output | 1 | Any interrupt flag set |
| host_tx_wr | input | 1 | Transmit FIFO word write strobe |
| host_tx_wdata | input | 32 | Transmit word, little-endian |
| host_rx_rd | input | 1 | Receive FIFO word read strobe |
| host_rx_rdata | output | 32 | Receive word, valid the cycle after the strobe |
| fr_mode | output | 8 | Mode byte for the framer |
| fr_fill | output | 8 | Idle fill byte for the framer |
| fr_tx_req | input | 1 | Framer asks for the next transmit byte |
| fr_tx_valid | output | 1 | Transmit byte present |
| fr_tx_byte | output | 8 | Transmit byte |
| fr_tx_end | output | 1 | Byte is the last of a frame |
| fr_rx_valid | input | 1 | Received byte strobe |
| fr_rx_byte | input | 8 | Received byte |
| fr_rx_end | input | 1 | Received byte ends a frame |
| fr_rx_chk | input | 3 | Frame check pattern at frame end |

## Verification
Transmit blocks are driven with random lengths, FIFO sizes, message-end settings and transparent or HDLC mode. This separates the zero-means-full length rule, the byte order within words and the placement of the frame end. Directed sequences cover an underrun after an open frame, and no underrun after a closed one. They also cover a transmit reset with a block loaded and extra words dropped past the block length. Receive frames of random length are checked for length encoding, end and check fields, and word packing. They run in both modes, and in transparent mode stray end markers must be ignored. Overflow stickiness, receive reset, and a status read that collides with a new event check the flag latches.

// File: rtl/hdlc_fifo_pkg.sv
package hdlc_fifo_pkg;
  // command byte bit positions
  localparam int CMD_TXRST = 7;
  localparam int CMD_RXRST = 5;
  localparam int CMD_MEND  = 0;
  // mode byte bit positions
  localparam int MODE_TRANSP = 1;
  localparam int MODE_BIG    = 5;

  typedef struct packed {
    logic [7:0] fill;
    logic [7:0] mode;
    logic [7:0] len;
    logic [7:0] cmd;
  } ctrl_word_t;
endpackage

// File: rtl/hdlc_tx_path.sv
module hdlc_tx_path #(
  parameter int FIFO_BYTES = 128
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              flush,
  input  logic [$clog2(FIFO_BYTES+1)-1:0]   blk_len,
  input  logic                              blk_mend,
  input  logic                              host_wr,
  input  logic [31:0]                       host_wdata,
  input  logic                              req,
  output logic [7:0]                        tx_byte,
  output logic                              tx_valid,
  output logic                              tx_end,
  output logic                              done_evt,
  output logic                              undr_evt
);
  localparam int CW    = $clog2(FIFO_BYTES + 1);
  localparam int WORDS = FIFO_BYTES / 4;
  localparam int AW    = $clog2(WORDS);

  logic [31:0]   mem [WORDS];
  logic [31:0]   rd_word;
  logic [CW-1:0] wr_cnt, rd_cnt, cur_len;
  logic          cur_end, loaded, open_q;
  logic [1:0]    lane_q;
  logic [CW-1:0] wr_next;
  logic          take_word, send, last;

  assign wr_next   = wr_cnt + CW'(4);
  assign take_word = host_wr && !loaded;
  assign send      = req && loaded;
  assign last      = (rd_cnt + CW'(1)) == cur_len;
  assign done_evt  = send && last && !flush;
  assign undr_evt  = req && !loaded && open_q && !flush;

  // word storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (take_word) mem[wr_cnt[AW+1:2]] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (send) rd_word <= mem[rd_cnt[AW+1:2]];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_cnt   <= '0;
      rd_cnt   <= '0;
      cur_len  <= '0;
      cur_end  <= 1'b0;
      loaded   <= 1'b0;
      open_q   <= 1'b0;
      tx_valid <= 1'b0;
      tx_end   <= 1'b0;
      lane_q   <= 2'd0;
    end else begin
      tx_valid <= 1'b0;
      tx_end   <= 1'b0;
      if (take_word) begin
        if (wr_next >= blk_len) begin
          loaded  <= 1'b1;
          cur_len <= blk_len;
          cur_end <= blk_mend;
          wr_cnt  <= '0;
        end else begin
          wr_cnt <= wr_next;
        end
      end
      if (send) begin
        tx_valid <= 1'b1;
        lane_q   <= rd_cnt[1:0];
        tx_end   <= last && cur_end;
        open_q   <= !(last && cur_end);
        if (last) begin
          loaded <= 1'b0;
          rd_cnt <= '0;
        end else begin
          rd_cnt <= rd_cnt + CW'(1);
        end
      end
    end
  end

  always_comb begin
    case (lane_q)
      2'd0:    tx_byte = rd_word[7:0];
      2'd1:    tx_byte = rd_word[15:8];
      2'd2:    tx_byte = rd_word[23:16];
      default: tx_byte = rd_word[31:24];
    endcase
  end
endmodule

// File: rtl/hdlc_rx_path.sv
module hdlc_rx_path #(
  parameter int FIFO_BYTES = 128
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              flush,
  input  logic [$clog2(FIFO_BYTES+1)-1:0]   blk_size,
  input  logic                              transp,
  input  logic                              in_valid,
  input  logic [7:0]                        in_byte,
  input  logic                              in_end,
  input  logic [2:0]                        in_chk,
  input  logic                              host_rd,
  output logic [31:0]                       rdata,
  output logic                              blk_rdy,
  output logic [$clog2(FIFO_BYTES+1)-1:0]   blk_len,
  output logic                              blk_mend,
  output logic [2:0]                        blk_chk,
  output logic                              ovf,
  output logic                              ready_evt
);
  localparam int CW    = $clog2(FIFO_BYTES + 1);
  localparam int WORDS = FIFO_BYTES / 4;
  localparam int AW    = $clog2(WORDS);

  logic [31:0]   mem [WORDS];
  logic [31:0]   acc, merged;
  logic [CW-1:0] cnt, cnt_next, nwords;
  logic [AW-1:0] rd_idx;
  logic [1:0]    lane;
  logic          accept, close_end, close_full, close, wr_en, last_rd;

  assign lane       = cnt[1:0];
  assign cnt_next   = cnt + CW'(1);
  assign accept     = in_valid && !blk_rdy && !flush;
  assign close_end  = in_end && !transp;
  assign close_full = cnt_next == blk_size;
  assign close      = close_end || close_full;
  assign wr_en      = accept && (lane == 2'd3 || close);
  assign ready_evt  = accept && close;
  assign nwords     = (blk_len + CW'(3)) >> 2;
  assign last_rd    = (CW'(rd_idx) + CW'(1)) == nwords;

  always_comb begin
    merged = acc;
    case (lane)
      2'd0:    merged[7:0]   = in_byte;
      2'd1:    merged[15:8]  = in_byte;
      2'd2:    merged[23:16] = in_byte;
      default: merged[31:24] = in_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[cnt[AW+1:2]] <= merged;
  end

  always_ff @(posedge clk) begin
    if (host_rd) rdata <= blk_rdy ? mem[rd_idx] : 32'd0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt      <= '0;
      acc      <= '0;
      rd_idx   <= '0;
      blk_rdy  <= 1'b0;
      blk_len  <= '0;
      blk_mend <= 1'b0;
      blk_chk  <= 3'd0;
      ovf      <= 1'b0;
    end else begin
      if (in_valid && blk_rdy) ovf <= 1'b1;
      if (accept) begin
        if (close) begin
          cnt      <= '0;
          acc      <= '0;
          blk_rdy  <= 1'b1;
          blk_len  <= cnt_next;
          blk_mend <= close_end;
          blk_chk  <= close_end ? in_chk : 3'd0;
        end else begin
          cnt <= cnt_next;
          acc <= (lane == 2'd3) ? 32'd0 : merged;
        end
      end
      if (host_rd && blk_rdy) begin
        if (last_rd) begin
          rd_idx   <= '0;
          blk_rdy  <= 1'b0;
          blk_len  <= '0;
          blk_mend <= 1'b0;
          blk_chk  <= 3'd0;
        end else begin
          rd_idx <= rd_idx + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_chan_if.sv
module hdlc_chan_if
  import hdlc_fifo_pkg::*;
#(
  parameter int         FIFO_BYTES  = 128,
  parameter int         SMALL_BYTES = 32,
  parameter logic [3:0] VERSION     = 4'h2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_ctrl_wr,
  input  logic [31:0] host_ctrl_wdata,
  input  logic        host_stat_rd,
  output logic [31:0] stat_word,
  output logic        irq,
  input  logic        host_tx_wr,
  input  logic [31:0] host_tx_wdata,
  input  logic        host_rx_rd,
  output logic [31:0] host_rx_rdata,
  output logic [7:0]  fr_mode,
  output logic [7:0]  fr_fill,
  input  logic        fr_tx_req,
  output logic        fr_tx_valid,
  output logic [7:0]  fr_tx_byte,
  output logic        fr_tx_end,
  input  logic        fr_rx_valid,
  input  logic [7:0]  fr_rx_byte,
  input  logic        fr_rx_end,
  input  logic [2:0]  fr_rx_chk
);
  localparam int CW = $clog2(FIFO_BYTES + 1);

  ctrl_word_t    wcmd;
  logic [7:0]    len_q, mode_q, fill_q;
  logic          mend_q;
  logic          tx_rst, rx_rst;
  logic [CW-1:0] fs, eff_len, rx_len, rml;
  logic          tx_done, tx_undr, rx_evt;
  logic          rx_mend, rx_ovf, rx_rdy;
  logic [2:0]    rx_chk;
  logic          xpr_q, xdu_q, rpr_q;
  logic          unused_cmd_bits;

  assign wcmd            = ctrl_word_t'(host_ctrl_wdata);
  assign tx_rst          = host_ctrl_wr && wcmd.cmd[CMD_TXRST];
  assign rx_rst          = host_ctrl_wr && wcmd.cmd[CMD_RXRST];
  assign unused_cmd_bits = ^{wcmd.cmd[6], wcmd.cmd[4:1], rx_rdy};

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= 8'd0;
      mode_q <= 8'd0;
      fill_q <= 8'd0;
      mend_q <= 1'b0;
    end else if (host_ctrl_wr) begin
      len_q  <= wcmd.len;
      mode_q <= wcmd.mode;
      fill_q <= wcmd.fill;
      mend_q <= wcmd.cmd[CMD_MEND];
    end
  end

  assign fs = mode_q[MODE_BIG] ? CW'(FIFO_BYTES) : CW'(SMALL_BYTES);

  always_comb begin
    if (len_q == 8'd0 || 9'(len_q) > 9'(fs)) eff_len = fs;
    else                                      eff_len = CW'(len_q);
  end

  hdlc_tx_path #(.FIFO_BYTES(FIFO_BYTES)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .flush      (tx_rst),
    .blk_len    (eff_len),
    .blk_mend   (mend_q && !mode_q[MODE_TRANSP]),
    .host_wr    (host_tx_wr),
    .host_wdata (host_tx_wdata),
    .req        (fr_tx_req),
    .tx_byte    (fr_tx_byte),
    .tx_valid   (fr_tx_valid),
    .tx_end     (fr_tx_end),
    .done_evt   (tx_done),
    .undr_evt   (tx_undr)
  );

  hdlc_rx_path #(.FIFO_BYTES(FIFO_BYTES)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .flush     (rx_rst),
    .blk_size  (fs),
    .transp    (mode_q[MODE_TRANSP]),
    .in_valid  (fr_rx_valid),
    .in_byte   (fr_rx_byte),
    .in_end    (fr_rx_end),
    .in_chk    (fr_rx_chk),
    .host_rd   (host_rx_rd),
    .rdata     (host_rx_rdata),
    .blk_rdy   (rx_rdy),
    .blk_len   (rx_len),
    .blk_mend  (rx_mend),
    .blk_chk   (rx_chk),
    .ovf       (rx_ovf),
    .ready_evt (rx_evt)
  );

  // latched interrupt flags: a new event beats the clear of a status read
  always_ff @(posedge clk) begin
    if (rst) begin
      xpr_q <= 1'b0;
      xdu_q <= 1'b0;
      rpr_q <= 1'b0;
    end else begin
      xpr_q <= (tx_done || tx_rst) || (xpr_q && !host_stat_rd);
      xdu_q <= tx_undr || (xdu_q && !host_stat_rd);
      rpr_q <= rx_evt || (rpr_q && !host_stat_rd);
    end
  end

  assign rml       = (rx_len == fs) ? '0 : rx_len;
  assign stat_word = {4'd0, VERSION, 9'd0, 7'(rml), xpr_q, xdu_q, rpr_q,
                      rx_ovf, rx_chk, rx_mend};
  assign irq       = xpr_q || xdu_q || rpr_q;
  assign fr_mode   = mode_q;
  assign fr_fill   = fill_q;
endmodule

// File: rtl/hdlc_chan_if_chk.sv
module hdlc_chan_if_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_ctrl_wr,
  input logic [31:0] host_ctrl_wdata,
  input logic        host_stat_rd,
  input logic        fr_tx_req,
  input logic        fr_rx_valid,
  input logic        fr_tx_valid,
  input logic        fr_tx_end,
  input logic [31:0] stat_word
);
  // R4: a byte only ever answers a request of the previous cycle
  p_valid_follows_req_r4: assert property (@(posedge clk) disable iff (rst)
    fr_tx_valid |-> $past(fr_tx_req));

  // R5: frame end only rides on a delivered byte
  p_end_with_byte_r5: assert property (@(posedge clk) disable iff (rst)
    fr_tx_end |-> fr_tx_valid);

  // R8: transmit reset kills the next byte
  p_txrst_no_byte_r8: assert property (@(posedge clk) disable iff (rst)
    host_ctrl_wr && host_ctrl_wdata[7] |=> !fr_tx_valid);

  // R7: underrun only follows a request
  p_undr_from_req_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_word[6]) |-> $past(fr_tx_req));

  // R9: receive pool ready only follows a received byte
  p_rpr_from_byte_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_word[5]) |-> $past(fr_rx_valid));

  // R13: a status read with no competing event leaves all flags clear
  p_read_clears_r13: assert property (@(posedge clk) disable iff (rst)
    host_stat_rd && !host_ctrl_wr && !fr_tx_req && !fr_rx_valid
    |=> stat_word[7:5] == 3'b000);

  // R12: overflow holds until a receive reset
  p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    stat_word[4] && !(host_ctrl_wr && host_ctrl_wdata[5]) |=> stat_word[4]);

  // R12: receive reset clears overflow and the pending block fields
  p_rxrst_clears_r12: assert property (@(posedge clk) disable iff (rst)
    host_ctrl_wr && host_ctrl_wdata[5]
    |=> !stat_word[4] && !stat_word[0] && stat_word[14:8] == 7'd0);
endmodule

bind hdlc_chan_if hdlc_chan_if_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .host_ctrl_wr    (host_ctrl_wr),
  .host_ctrl_wdata (host_ctrl_wdata),
  .host_stat_rd    (host_stat_rd),
  .fr_tx_req       (fr_tx_req),
  .fr_rx_valid     (fr_rx_valid),
  .fr_tx_valid     (fr_tx_valid),
  .fr_tx_end       (fr_tx_end),
  .stat_word       (stat_word)
);

// File: tb/hdlc_chan_if_tb.sv
module hdlc_chan_if_tb;
  localparam logic [3:0] VER = 4'h2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_ctrl_wr = 0, host_stat_rd = 0, host_tx_wr = 0, host_rx_rd = 0;
  logic [31:0] host_ctrl_wdata = 0, host_tx_wdata = 0;
  logic        fr_tx_req = 0, fr_rx_valid = 0, fr_rx_end = 0;
  logic [7:0]  fr_rx_byte = 0;
  logic [2:0]  fr_rx_chk = 0;
  logic [31:0] stat_word, host_rx_rdata;
  logic        irq, fr_tx_valid, fr_tx_end;
  logic [7:0]  fr_mode, fr_fill, fr_tx_byte;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hdlc_chan_if #(.FIFO_BYTES(128), .SMALL_BYTES(32), .VERSION(VER)) u_dut (
    .clk(clk), .rst(rst),
    .host_ctrl_wr(host_ctrl_wr), .host_ctrl_wdata(host_ctrl_wdata),
    .host_stat_rd(host_stat_rd), .stat_word(stat_word), .irq(irq),
    .host_tx_wr(host_tx_wr), .host_tx_wdata(host_tx_wdata),
    .host_rx_rd(host_rx_rd), .host_rx_rdata(host_rx_rdata),
    .fr_mode(fr_mode), .fr_fill(fr_fill),
    .fr_tx_req(fr_tx_req), .fr_tx_valid(fr_tx_valid), .fr_tx_byte(fr_tx_byte),
    .fr_tx_end(fr_tx_end),
    .fr_rx_valid(fr_rx_valid), .fr_rx_byte(fr_rx_byte), .fr_rx_end(fr_rx_end),
    .fr_rx_chk(fr_rx_chk)
  );

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(input logic [7:0] fill, input logic [7:0] mode,
                                       input logic [7:0] len, input logic [7:0] cmd);
    return {fill, mode, len, cmd};
  endfunction

  function automatic int exp_rml(input int len, input int fs);
    return (len == fs) ? 0 : len;
  endfunction

  task automatic ctrl_wr(input logic [31:0] w);
    host_ctrl_wr = 1; host_ctrl_wdata = w;
    @(negedge clk);
    host_ctrl_wr = 0;
  endtask

  task automatic tx_word(input logic [31:0] w);
    host_tx_wr = 1; host_tx_wdata = w;
    @(negedge clk);
    host_tx_wr = 0;
  endtask

  task automatic tx_pull(output logic v, output logic [7:0] b, output logic e);
    fr_tx_req = 1;
    @(negedge clk);
    fr_tx_req = 0;
    v = fr_tx_valid; b = fr_tx_byte; e = fr_tx_end;
  endtask

  task automatic rx_push(input logic [7:0] b, input logic e, input logic [2:0] c);
    fr_rx_valid = 1; fr_rx_byte = b; fr_rx_end = e; fr_rx_chk = c;
    @(negedge clk);
    fr_rx_valid = 0; fr_rx_end = 0;
  endtask

  task automatic rx_read(output logic [31:0] w);
    host_rx_rd = 1;
    @(negedge clk);
    host_rx_rd = 0;
    w = host_rx_rdata;
  endtask

  task automatic stat_read(output logic [31:0] s);
    s = stat_word;
    host_stat_rd = 1;
    @(negedge clk);
    host_stat_rd = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired before the test sequence ended");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] s, w;
    logic        v, e;
    logic [7:0]  b;
    logic [7:0]  bytes [0:127];

    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 / R14: reset state and version field
    chk_eq("R1", "status after reset", stat_word, {4'd0, VER, 24'd0});
    chk_eq("R1", "irq after reset", irq, 0);
    chk_eq("R1", "tx valid after reset", fr_tx_valid, 0);
    chk_eq("R14", "version bits", stat_word[27:24], VER);

    // R2: byte layout of the control word
    ctrl_wr(ctrl(8'h7E, 8'h05, 8'h00, 8'h00));
    chk_eq("R2", "mode byte", fr_mode, 8'h05);
    chk_eq("R2", "fill byte", fr_fill, 8'h7E);
    chk_eq("R2", "plain write raises no flag", stat_word[7:5], 0);

    // transmit reset to a clean state, check R6 on reset
    ctrl_wr(ctrl(8'h7E, 8'h01, 8'h06, 8'h81));
    chk_eq("R6", "pool ready after tx reset", stat_word[7], 1);
    chk_eq("R13", "irq follows flags", irq, 1);
    stat_read(s);
    chk_eq("R13", "flags cleared by read", stat_word[7:5], 0);
    chk_eq("R13", "irq low after read", irq, 0);

    // directed HDLC block of 6 bytes with message end
    tx_word(32'h44332211);
    tx_word(32'hCCBBAA55);
    for (int i = 0; i < 6; i++) begin
      tx_pull(v, b, e);
      chk_eq("R4", "byte valid after request", v, 1);
      chk_eq("R3", "directed byte", b, (i < 4) ? 8'(32'h44332211 >> (8*i))
                                                : 8'(32'hCCBBAA55 >> (8*(i-4))));
      chk_eq("R5", "end marker position", e, (i == 5));
    end
    @(negedge clk);
    chk_eq("R4", "valid drops without request", fr_tx_valid, 0);
    chk_eq("R6", "pool ready after last byte", stat_word[7], 1);
    stat_read(s);
    tx_pull(v, b, e);
    chk_eq("R7", "no byte after closed frame", v, 0);
    chk_eq("R7", "no underrun after closed frame", stat_word[6], 0);

    // random transmit blocks
    for (int it = 0; it < 14; it++) begin
      bit big, tr, xme;
      int fs, xml, len;
      logic [7:0] mode;
      big = ($urandom % 3) == 0;
      tr  = ($urandom % 4) == 0;
      xme = $urandom % 2;
      if (it == 0) begin big = 0; tr = 0; xme = 1; end
      if (it == 1) begin big = 1; tr = 0; xme = 1; end
      fs  = big ? 128 : 32;
      xml = (it < 2) ? 0 : int'($urandom % fs);
      len = (xml == 0) ? fs : xml;
      mode = (big ? 8'h20 : 8'h00) | (tr ? 8'h02 : 8'h01);
      ctrl_wr(ctrl(8'hFF, mode, 8'(xml), {7'd0, xme}));
      for (int wi = 0; wi < (len + 3) / 4; wi++) begin
        w = $urandom;
        for (int k = 0; k < 4; k++) bytes[wi*4+k] = w[8*k +: 8];
        tx_word(w);
      end
      for (int i = 0; i < len; i++) begin
        tx_pull(v, b, e);
        chk_eq("R4", "random byte valid", v, 1);
        chk_eq("R3", "random byte value", b, bytes[i]);
        chk_eq("R5", "random end marker", e, (i == len - 1) && xme && !tr);
      end
      chk_eq("R6", "pool ready after random block", stat_word[7], 1);
      stat_read(s);
    end

    // underrun: open frame, then empty request
    ctrl_wr(ctrl(8'hFF, 8'h01, 8'h04, 8'h80));
    stat_read(s);
    tx_word(32'hDEADBEEF);
    for (int i = 0; i < 4; i++) tx_pull(v, b, e);
    chk_eq("R5", "no end without message-end bit", e, 0);
    stat_read(s);
    tx_pull(v, b, e);
    chk_eq("R7", "no byte on empty", v, 0);
    chk_eq("R7", "underrun on open frame", stat_word[6], 1);
    ctrl_wr(ctrl(8'hFF, 8'h01, 8'h04, 8'h80));
    chk_eq("R6", "pool ready after reset in underrun", stat_word[7], 1);
    stat_read(s);
    tx_pull(v, b, e);
    chk_eq("R8", "no byte after reset", v, 0);
    chk_eq("R8", "no underrun after reset", stat_word[6], 0);
    // loaded block dropped by reset
    tx_word(32'h01020304);
    ctrl_wr(ctrl(8'hFF, 8'h01, 8'h04, 8'h80));
    tx_pull(v, b, e);
    chk_eq("R8", "loaded block dropped", v, 0);

    // padding dropped, extra word dropped while block waits
    ctrl_wr(ctrl(8'hFF, 8'h01, 8'h05, 8'h01));
    tx_word(32'hA3A2A1A0);
    tx_word(32'hB3B2B1B0);
    tx_word(32'hC3C2C1C0);
    for (int i = 0; i < 5; i++) tx_pull(v, b, e);
    chk_eq("R3", "fifth byte of partial block", b, 8'hB0);
    chk_eq("R5", "end on fifth byte", e, 1);
    stat_read(s);
    tx_pull(v, b, e);
    chk_eq("R3", "padding bytes not sent", v, 0);
    chk_eq("R7", "closed frame no underrun", stat_word[6], 0);
    ctrl_wr(ctrl(8'hFF, 8'h01, 8'h04, 8'h01));
    tx_word(32'hD3D2D1D0);
    tx_pull(v, b, e);
    chk_eq("R3", "extra word was dropped", b, 8'hD0);
    for (int i = 0; i < 3; i++) tx_pull(v, b, e);
    stat_read(s);

    // receive: directed 5-byte frame
    ctrl_wr(ctrl(8'h00, 8'h01, 8'h00, 8'h20));
    rx_push(8'h10, 0, 0); rx_push(8'h21, 0, 0); rx_push(8'h32, 0, 0);
    rx_push(8'h43, 0, 0);
    chk_eq("R9", "no pool ready mid frame", stat_word[5], 0);
    rx_push(8'h54, 1, 3'b011);
    chk_eq("R9", "pool ready at frame end", stat_word[5], 1);
    chk_eq("R9", "length field", stat_word[14:8], 5);
    chk_eq("R10", "end bit", stat_word[0], 1);
    chk_eq("R10", "check pattern", stat_word[3:1], 3'b011);
    rx_read(w);
    chk_eq("R11", "first word", w, 32'h43322110);
    rx_read(w);
    chk_eq("R11", "padded word", w, 32'h00000054);
    chk_eq("R11", "length cleared after release", stat_word[14:8], 0);
    chk_eq("R11", "end cleared after release", stat_word[0], 0);
    rx_read(w);
    chk_eq("R11", "empty read", w, 0);
    stat_read(s);

    // random receive blocks
    for (int it = 0; it < 10; it++) begin
      bit big, tr;
      int fs, len;
      logic [2:0] c;
      big = ($urandom % 3) == 0;
      tr  = ($urandom % 3) == 0;
      if (it == 0) begin big = 0; tr = 0; end
      fs  = big ? 128 : 32;
      len = tr ? fs : 1 + int'($urandom % fs);
      if (it == 0) len = 32;
      c   = 3'($urandom);
      ctrl_wr(ctrl(8'h00, (big ? 8'h20 : 8'h00) | (tr ? 8'h02 : 8'h01), 8'h00, 8'h20));
      stat_read(s);
      for (int i = 0; i < len; i++) begin
        bytes[i] = 8'($urandom);
        rx_push(bytes[i], tr ? (($urandom % 5) == 0) : (i == len - 1), c);
      end
      chk_eq("R9", "random pool ready", stat_word[5], 1);
      chk_eq("R9", "random length field", stat_word[14:8], exp_rml(len, fs));
      chk_eq("R10", "random end bit", stat_word[0], !tr);
      chk_eq("R10", "random check field", stat_word[3:1], tr ? 3'd0 : c);
      for (int wi = 0; wi < (len + 3) / 4; wi++) begin
        logic [31:0] ew;
        ew = 0;
        for (int k = 0; k < 4; k++)
          if (wi*4 + k < len) ew[8*k +: 8] = bytes[wi*4+k];
        rx_read(w);
        chk_eq("R11", "random word", w, ew);
      end
      chk_eq("R11", "released", stat_word[14:8], 0);
    end

    // transparent: end marker ignored
    ctrl_wr(ctrl(8'h00, 8'h02, 8'h00, 8'h20));
    stat_read(s);
    rx_push(8'h01, 1, 3'b011); rx_push(8'h02, 1, 0); rx_push(8'h03, 1, 0);
    chk_eq("R9", "transparent end ignored", stat_word[5], 0);
    chk_eq("R9", "transparent no length", stat_word[14:8], 0);

    // overflow
    ctrl_wr(ctrl(8'h00, 8'h01, 8'h00, 8'h20));
    stat_read(s);
    rx_push(8'hA0, 0, 0); rx_push(8'hA1, 1, 3'b011);
    rx_push(8'hEE, 1, 0);
    chk_eq("R12", "overflow set", stat_word[4], 1);
    chk_eq("R12", "pending block kept", stat_word[14:8], 2);
    rx_read(w);
    chk_eq("R12", "dropped byte not stored", w, 32'h0000A1A0);
    chk_eq("R12", "overflow sticky after read", stat_word[4], 1);
    rx_push(8'hB0, 1, 3'b011);
    chk_eq("R12", "next frame accepted", stat_word[14:8], 1);
    ctrl_wr(ctrl(8'h00, 8'h01, 8'h00, 8'h20));
    chk_eq("R12", "overflow cleared by rx reset", stat_word[4], 0);
    chk_eq("R12", "block dropped by rx reset", stat_word[14:8], 0);
    chk_eq("R12", "end cleared by rx reset", stat_word[0], 0);
    stat_read(s);

    // status read colliding with a closing byte
    fr_rx_valid = 1; fr_rx_byte = 8'h5A; fr_rx_end = 1; fr_rx_chk = 3'b011;
    host_stat_rd = 1;
    @(negedge clk);
    fr_rx_valid = 0; fr_rx_end = 0; host_stat_rd = 0;
    chk_eq("R13", "event beats clear", stat_word[5], 1);
    chk_eq("R13", "irq with surviving flag", irq, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule